// File: doc/BRIEF.md
# PWM Fault Trip and Interrupt Controller

This block collects the events of a four-pair PWM peripheral and turns them into sticky interrupt flags. It watches an asynchronous, active-low fault pin and the free-running counter of each output pair. When the fault pin falls and the fault function is armed, it pulses a request that clears the peripheral's global enable bit and latches a fault flag. When interrupts are armed, each pair latches its own flag in the cycle its counter wraps from its period value back to zero.

Software reads the flags through a status vector and drops them with a write-one-to-clear strobe vector. The interrupt lines follow the flags. In H-bridge mode pairs 0 and 1 drive one bridge together, so both of their wrap events are steered to the pair-0 flag and the pair-1 interrupt line stays quiet. Pairs 2 and 3 keep working on their own. The counters themselves are produced elsewhere. So is the enable register: it stays low after a fault until software writes it again.

Top module: `pwm_fault_irq_ctrl`

## Requirements
- R1: With `fault_arm_i` high, a falling edge on `fault_n_i` passes a two-flop synchronizer and an edge detector. On the third rising clock edge after the pin goes low, `en_clear_o` goes high for exactly one cycle and status bit 4 (the fault flag) sets.
- R2: With `fault_arm_i` low, edges on `fault_n_i` are ignored: `en_clear_o` stays low and status bit 4 stays clear.
- R3: A 1 in bit 4 of `clr_i` clears the fault flag at the next rising edge.
- R4: With `irq_arm_i` high, pair k's flag (status bit k, k = 0..3) sets at the rising edge where the counter reads 0 and the counter read `per_i` of pair k at the previous edge. With `irq_arm_i` low, no pair flag sets.
- R5: A 1 in bit k (0..3) of `clr_i` clears pair k's flag at the next edge and leaves the other flags unchanged.
- R6: With `hbridge_i` high, a wrap of pair 0 or pair 1 sets only the pair-0 flag, and `irq_o[1]` is held low even if status bit 1 was set before. Pairs 2 and 3 behave as in R4.
- R7: A flag stays set until it is cleared. A counter that stays at 0 after a wrap does not set the flag again.
- R8: When an event and a clear of the same flag fall in one cycle, the flag ends up set.
- R9: During and right after synchronous reset, all status bits, all interrupt lines and `en_clear_o` are 0.
- R10: A counter that reaches 0 from any value other than its period does not set a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_n_i | input | 1 | Asynchronous active-low fault pin |
| cnt_i | input | NUM_PAIRS*CNT_W | Packed pair counters, pair k at bits [k*CNT_W +: CNT_W] |
| per_i | input | NUM_PAIRS*CNT_W | Packed pair period values, same layout |
| irq_arm_i | input | 1 | Enables the pair wrap flags |
| fault_arm_i | input | 1 | Enables the fault function |
| hbridge_i | input | 1 | H-bridge mode for pairs 0 and 1 |
| clr_i | input | NUM_PAIRS+1 | Write-one-to-clear strobes; bits 0..3 pairs, bit 4 fault |
| en_clear_o | output | 1 | One-cycle request to clear the global enable |
| irq_o | output | NUM_PAIRS+1 | Interrupt lines, same bit order as the status |
| status_o | output | NUM_PAIRS+1 | Sticky flags; bits 0..3 pairs, bit 4 fault |

## Verification
The assertions assume two things about the inputs. Each counter moves the way a counter does, so a wrap is a period-to-zero step and not an arbitrary jump. The arm and mode inputs come from registers in the same clock domain. The stimulus keeps to this: it changes counters and controls only at falling clock edges, sets the periods before any wrap, and holds idle pairs at a value that is neither 0 nor their period. The fault pin is the only asynchronous input, and the bench toggles it half a cycle away from the sampling edge.

// File: rtl/pwm_irq_pkg.sv
package pwm_irq_pkg;
  // Default sizing shared by the controller and its bench
  localparam int unsigned PAIRS_DEF  = 4;
  localparam int unsigned CNT_W_DEF  = 16;
  localparam int unsigned SYNC_DEF   = 2;
  // Pairs that form the bridge; the second folds into the first
  localparam int unsigned HB_MAIN    = 0;
  localparam int unsigned HB_FOLDED  = 1;
endpackage

// File: rtl/pit_fault_sync.sv
module pit_fault_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n_i,
  output logic fall_o
);
  // sh[0..STAGES-1] synchronize, sh[STAGES] holds the previous synced value
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '1;
    else     sh_q <= {sh_q[STAGES-1:0], pin_n_i};
  end

  assign fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/pit_wrap_detect.sv
module pit_wrap_detect #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] per_i,
  output logic             wrap_o
);
  logic [CNT_W-1:0] prev_q;
  logic             vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      prev_q <= cnt_i;
      vld_q  <= 1'b1;
    end
  end

  assign wrap_o = vld_q && (prev_q == per_i) && (cnt_i == '0);
endmodule

// File: rtl/pit_flag_bank.sv
module pit_flag_bank #(
  parameter int unsigned NFLAG = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] set_i,
  input  logic [NFLAG-1:0] clr_i,
  output logic [NFLAG-1:0] flag_o
);
  logic [NFLAG-1:0] flag_q;

  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= (flag_q & ~clr_i) | set_i;
  end

  assign flag_o = flag_q;

  for (genvar g = 0; g < NFLAG; g++) begin : g_chk
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
      flag_q[g] && !clr_i[g] |=> flag_q[g]);                      // R7
    AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (rst)
      set_i[g] && clr_i[g] |=> flag_q[g]);                        // R8
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
      clr_i[g] && !set_i[g] |=> !flag_q[g]);                      // R5
  end
endmodule

// File: rtl/pwm_fault_irq_ctrl.sv
module pwm_fault_irq_ctrl
  import pwm_irq_pkg::*;
#(
  parameter int unsigned NUM_PAIRS = PAIRS_DEF,
  parameter int unsigned CNT_W     = CNT_W_DEF,
  parameter int unsigned SYNC_STG  = SYNC_DEF
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       fault_n_i,
  input  logic [NUM_PAIRS*CNT_W-1:0] cnt_i,
  input  logic [NUM_PAIRS*CNT_W-1:0] per_i,
  input  logic                       irq_arm_i,
  input  logic                       fault_arm_i,
  input  logic                       hbridge_i,
  input  logic [NUM_PAIRS:0]         clr_i,
  output logic                       en_clear_o,
  output logic [NUM_PAIRS:0]         irq_o,
  output logic [NUM_PAIRS:0]         status_o
);
  localparam int unsigned NFLAG     = NUM_PAIRS + 1;
  localparam int unsigned FAULT_IDX = NUM_PAIRS;

  logic                 fall;
  logic [NUM_PAIRS-1:0] wrap;
  logic [NUM_PAIRS-1:0] pair_ev;
  logic [NFLAG-1:0]     set_vec;
  logic [NFLAG-1:0]     flags;
  logic [NFLAG-1:0]     irq_mask;
  logic                 en_clr_q;

  pit_fault_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .pin_n_i(fault_n_i), .fall_o(fall)
  );

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
    pit_wrap_detect #(.CNT_W(CNT_W)) u_wrap (
      .clk(clk), .rst(rst),
      .cnt_i(cnt_i[k*CNT_W +: CNT_W]),
      .per_i(per_i[k*CNT_W +: CNT_W]),
      .wrap_o(wrap[k])
    );
    // Bridge mode steers the folded pair's event onto the main pair
    if (k == HB_MAIN) begin : g_main
      assign pair_ev[k] = wrap[k] | (hbridge_i & wrap[HB_FOLDED]);
    end else if (k == HB_FOLDED) begin : g_fold
      assign pair_ev[k] = wrap[k] & ~hbridge_i;
    end else begin : g_plain
      assign pair_ev[k] = wrap[k];
    end

    AST_PAIR_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
      !irq_arm_i && !status_o[k] |=> !status_o[k]);               // R4
  end

  assign set_vec = {fall & fault_arm_i, pair_ev & {NUM_PAIRS{irq_arm_i}}};

  pit_flag_bank #(.NFLAG(NFLAG)) u_flags (
    .clk(clk), .rst(rst), .set_i(set_vec), .clr_i(clr_i), .flag_o(flags)
  );

  always_ff @(posedge clk) begin
    if (rst) en_clr_q <= 1'b0;
    else     en_clr_q <= fall & fault_arm_i;
  end

  always_comb begin
    irq_mask            = '1;
    irq_mask[HB_FOLDED] = ~hbridge_i;
  end

  assign en_clear_o = en_clr_q;
  assign status_o   = flags;
  assign irq_o      = flags & irq_mask;

  AST_FAULT_PULSE_FLAG: assert property (@(posedge clk) disable iff (rst)
    en_clear_o |-> status_o[FAULT_IDX]);                          // R1
  AST_FAULT_PULSE_ONCE: assert property (@(posedge clk) disable iff (rst)
    en_clear_o |=> !en_clear_o);                                  // R1
  AST_FAULT_DISARMED: assert property (@(posedge clk) disable iff (rst)
    !fault_arm_i |=> !en_clear_o);                                // R2
  AST_FAULT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr_i[FAULT_IDX] && !fault_arm_i |=> !status_o[FAULT_IDX]);   // R3
  AST_HB_FOLDED_QUIET: assert property (@(posedge clk) disable iff (rst)
    hbridge_i && !status_o[HB_FOLDED] |=> !status_o[HB_FOLDED]);  // R6
  AST_RESET_CLEAN: assert property (@(posedge clk)
    rst |=> (status_o == '0) && !en_clear_o);                     // R9
endmodule

// File: tb/pwm_fault_irq_ctrl_tb.sv
module pwm_fault_irq_ctrl_tb_top;
  localparam int NP = 4;
  localparam int CW = 16;
  localparam int NF = NP + 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst, fault_n, irq_arm, fault_arm, hb, en_clr;
  logic [NP*CW-1:0] cnt, per;
  logic [NF-1:0]    clr, irq, status;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  pwm_fault_irq_ctrl #(.NUM_PAIRS(NP), .CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .fault_n_i(fault_n), .cnt_i(cnt), .per_i(per),
    .irq_arm_i(irq_arm), .fault_arm_i(fault_arm), .hbridge_i(hb),
    .clr_i(clr), .en_clear_o(en_clr), .irq_o(irq), .status_o(status)
  );

  // fields: pair[40:39] period[38:23] pre-wrap value[22:7] irq_arm[6] hbridge[5] expected[4:0]
  localparam logic [40:0] VEC [0:8] = '{
    {2'd0, 16'd10,  16'd10,  1'b1, 1'b0, 5'b00001},  // R4 pair 0
    {2'd1, 16'd20,  16'd20,  1'b1, 1'b0, 5'b00010},  // R4 pair 1
    {2'd2, 16'd7,   16'd7,   1'b1, 1'b0, 5'b00100},  // R4 pair 2
    {2'd3, 16'd255, 16'd255, 1'b1, 1'b0, 5'b01000},  // R4 pair 3
    {2'd2, 16'd10,  16'd9,   1'b1, 1'b0, 5'b00000},  // R10 not from period
    {2'd0, 16'd10,  16'd10,  1'b0, 1'b0, 5'b00000},  // R4 disarmed
    {2'd1, 16'd10,  16'd10,  1'b1, 1'b1, 5'b00001},  // R6 folded into pair 0
    {2'd3, 16'd10,  16'd10,  1'b1, 1'b1, 5'b01000},  // R6 pair 3 unaffected
    {2'd0, 16'd10,  16'd10,  1'b1, 1'b1, 5'b00001}   // R6 pair 0 in bridge
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic set_cnt(input int k, input logic [CW-1:0] v);
    cnt[k*CW +: CW] = v;
  endtask

  task automatic clear_all();
    clr = '1; tick(); clr = '0; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all R): actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [40:0] v;
    int seen;
    rst = 1'b1; fault_n = 1'b1; irq_arm = 1'b0; fault_arm = 1'b0; hb = 1'b0;
    clr = '0; cnt = {NP{16'd2}}; per = {NP{16'd100}};
    repeat (3) tick();
    chk("R9 status in reset", status, 0);
    chk("R9 en_clear in reset", en_clr, 0);
    rst = 1'b0;
    tick();
    chk("R9 status after reset", status, 0);
    chk("R9 irq after reset", irq, 0);

    // table of wrap scenarios
    for (int i = 0; i < 9; i++) begin
      v = VEC[i];
      irq_arm = v[6]; hb = v[5]; per = {NP{v[38:23]}};
      set_cnt(int'(v[40:39]), v[22:7]); tick();
      set_cnt(int'(v[40:39]), 16'd0);   tick();
      chk($sformatf("R4/R6/R10 vec%0d status", i), status, v[4:0]);
      chk($sformatf("R4/R6/R10 vec%0d irq", i), irq, v[4:0]);
      set_cnt(int'(v[40:39]), 16'd2);
      clear_all();
    end

    // R7: sticky, no retrigger while the counter stays at 0
    irq_arm = 1'b1; hb = 1'b0; per = {NP{16'd50}};
    set_cnt(2, 16'd50); tick(); set_cnt(2, 16'd0); tick();
    repeat (4) tick();
    chk("R7 flag held", status, 5'b00100);
    clr = 5'b00100; tick(); clr = '0;
    repeat (3) tick();
    chk("R7 no retrigger at 0", status, 0);
    set_cnt(2, 16'd2); tick();

    // R5: clear one pair flag only
    set_cnt(0, 16'd50); set_cnt(3, 16'd50); tick();
    set_cnt(0, 16'd0);  set_cnt(3, 16'd0);  tick();
    set_cnt(0, 16'd2);  set_cnt(3, 16'd2);
    chk("R5 two flags set", status, 5'b01001);
    clr = 5'b00001; tick(); clr = '0;
    chk("R5 only pair 0 cleared", status, 5'b01000);
    clear_all();

    // R8: event and clear in the same cycle
    set_cnt(1, 16'd50); tick();
    set_cnt(1, 16'd0); clr = 5'b00010; tick(); clr = '0;
    chk("R8 set wins over clear", status, 5'b00010);
    set_cnt(1, 16'd2);
    // R6: a pair-1 flag left from normal mode is masked in bridge mode
    hb = 1'b1; tick();
    chk("R6 irq1 masked", irq, 5'b00000);
    chk("R6 status1 kept", status, 5'b00010);
    hb = 1'b0; clear_all();

    // R1: armed fault
    fault_arm = 1'b1; fault_n = 1'b0;
    tick(); tick();
    chk("R1 no pulse before third edge", en_clr, 0);
    tick();
    chk("R1 pulse on third edge", en_clr, 1);
    chk("R1 fault flag", status, 5'b10000);
    chk("R1 fault irq", irq, 5'b10000);
    tick();
    chk("R1 pulse lasts one cycle", en_clr, 0);
    chk("R7 fault flag sticky", status, 5'b10000);
    fault_n = 1'b1;
    // R3: clear the fault flag
    clr = 5'b10000; tick(); clr = '0;
    chk("R3 fault flag cleared", status, 0);

    // R2: disarmed fault is ignored
    fault_arm = 1'b0;
    repeat (4) tick();
    fault_n = 1'b0;
    seen = 0;
    for (int j = 0; j < 6; j++) begin
      tick();
      if (en_clr) seen++;
    end
    chk("R2 no enable clear", seen, 0);
    chk("R2 no fault flag", status, 0);
    fault_n = 1'b1;
    tick();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule